// File: doc/BRIEF.md
# Receive Queue with Level Trigger and Automatic Flow Control

This block holds received characters between the serial receive shifter and the CPU. It stores up to 64 bytes in arrival order, reports how many are waiting, and raises a receive-ready status while the fill level is at or above a programmed trigger. The same trigger drives an automatic active-low request-to-send output, so the remote transmitter is told to pause before the queue can overflow.

Once the queue has stopped the remote side, request-to-send is released again only after the fill level has fallen a programmable number of characters below the trigger. This keeps the line from toggling on every character. A write that arrives while the queue is full is dropped and recorded in a sticky overrun flag. A flush strobe empties the queue in one cycle.

Top module: `rxq_trig_rts`

## Requirements
- R1: While `rst_ni` is low, `count_o`, `rx_rdy_o`, `rts_n_o`, `ovr_o` and `rd_data_o` are all 0.
- R2: Bytes are read back in the order they were written. `count_o` is the number of stored bytes and changes on the clock edge where a write or read is accepted. A write and a read in the same cycle leave the count unchanged. `rd_data_o` shows the popped byte from the clock edge on which `rd_en_i` was accepted.
- R3: A write while `count_o` equals 64 is dropped, even when a read is accepted in the same cycle. The count never exceeds 64.
- R4: A dropped write sets `ovr_o` on the next edge. `ovr_o` stays set until a cycle with `ovr_ack_i` high and no new drop. A drop in the same cycle as the acknowledge keeps it set.
- R5: A read while the queue is empty leaves `rd_data_o` holding the last byte read and leaves `count_o` unchanged.
- R6: `rx_rdy_o` is high exactly when `count_o` is at least the effective trigger. The effective trigger is `trig_i`, except that 0 counts as 1 and values above 64 count as 64. It follows `count_o` with no added delay.
- R7: While `rts_en_i` is low, `rts_n_o` is 0 from the next edge on.
- R8: While `rts_en_i` is high, a count at or above the effective trigger drives `rts_n_o` to 1 on the next edge.
- R9: While `rts_en_i` is high and `rts_n_o` is 1, it returns to 0 on the edge after the count is 0 or count + H is below the effective trigger. Otherwise it holds. H is taken from `hyst_i`: code 0 gives 0, 1 gives 4, 2 gives 6 and 3 gives 8.
- R10: `flush_i` empties the queue on the next edge. A write or read in the same cycle is ignored, and `rd_data_o` and `ovr_o` are not changed by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe from the receive shifter |
| wr_data_i | input | 8 | Received byte |
| rd_en_i | input | 1 | CPU read strobe |
| rd_data_o | output | 8 | Last byte read |
| flush_i | input | 1 | One-cycle queue flush strobe |
| trig_i | input | 7 | Trigger level in characters |
| rts_en_i | input | 1 | Automatic request-to-send enable |
| hyst_i | input | 2 | Request-to-send hysteresis code |
| ovr_ack_i | input | 1 | Overrun flag acknowledge (status read) |
| count_o | output | 7 | Number of stored bytes |
| rx_rdy_o | output | 1 | Receive-ready status, level at or above trigger |
| rts_n_o | output | 1 | Active-low request-to-send |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The bench first uses directed bursts: it fills past the trigger and drains one byte at a time. This separates the stop point from the release point for each hysteresis code, and shows whether release waits for count + H to drop below the trigger. Further directed cases cover overfilling to 64 with a read in the same cycle, back-to-back empty reads, a flush combined with a write and a read, trigger values 0 and above 64, and flow control switched off. Each case separates one corner from its neighbour: a drop from an accepted write, a stale read from a pop, and a trigger below H where release waits for empty. A long run of random writes, reads, acknowledges and configuration changes then mixes these corners. A behavioural queue model is compared against every output on every cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int unsigned RXQ_DEPTH = 64;
  localparam int unsigned RXQ_DW    = 8;

  // characters below the trigger at which flow control is released
  function automatic int hyst_chars(input logic [1:0] code);
    case (code)
      2'd0:    return 0;
      2'd1:    return 4;
      2'd2:    return 6;
      default: return 8;
    endcase
  endfunction

  // trigger as used by the comparators: clamped into 1..depth
  function automatic int eff_trig(input int trig, input int depth);
    if (trig < 1)     return 1;
    if (trig > depth) return depth;
    return trig;
  endfunction

  // condition under which a stopped remote sender may resume
  function automatic logic release_ok(input int cnt, input int trig_eff,
                                      input logic [1:0] code);
    return (cnt == 0) || ((cnt + hyst_chars(code)) < trig_eff);
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH = rxq_pkg::RXQ_DEPTH,
  parameter int unsigned DW    = rxq_pkg::RXQ_DW,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          wr_req_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_req_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] count_o,
  output logic          wr_drop_o
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] rd_q;

  // named events for the assertions
  logic wr_ok, rd_ok, is_full, is_empty;

  assign is_full   = (cnt_q == FULL);
  assign is_empty  = (cnt_q == '0);
  assign wr_ok     = wr_req_i && !flush_i && !is_full;
  assign rd_ok     = rd_req_i && !flush_i && !is_empty;
  assign wr_drop_o = wr_req_i && !flush_i && is_full;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem[wptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      rd_q   <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_ok) wptr_q <= bump(wptr_q);
      if (rd_ok) begin
        rptr_q <= bump(rptr_q);
        rd_q   <= mem[rptr_q];
      end
      cnt_q <= cnt_q + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  assign rd_data_o = rd_q;
  assign count_o   = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);  // R3
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_full && wr_req_i && !rd_req_i && !flush_i) |=> is_full);  // R3
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && is_empty) |=> ($stable(rd_data_o) && is_empty == !$past(wr_ok)));  // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (is_empty && $stable(rd_data_o)));  // R10

endmodule

// File: rtl/rxq_ovr.sv
module rxq_ovr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drop_i,
  input  logic ack_i,
  output logic ovr_o
);

  logic ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ovr_q <= 1'b0;
    else if (drop_i) ovr_q <= 1'b1;
    else if (ack_i)  ovr_q <= 1'b0;
  end

  assign ovr_o = ovr_q;

  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !ack_i) |=> ovr_q);  // R4
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> ovr_q);  // R4

endmodule

// File: rtl/rxq_rts.sv
module rxq_rts #(
  parameter int unsigned DEPTH = rxq_pkg::RXQ_DEPTH,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [CW-1:0] trig_i,
  input  logic [1:0]    hyst_i,
  input  logic [CW-1:0] count_i,
  output logic          rts_n_o
);

  import rxq_pkg::*;

  logic rts_q, rts_d;
  logic at_trig, may_release;
  int   trig_eff;

  assign trig_eff    = eff_trig(int'(trig_i), int'(DEPTH));
  assign at_trig     = int'(count_i) >= trig_eff;
  assign may_release = release_ok(int'(count_i), trig_eff, hyst_i);

  always_comb begin
    rts_d = rts_q;
    if (!en_i)            rts_d = 1'b0;
    else if (at_trig)     rts_d = 1'b1;
    else if (may_release) rts_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rts_q <= 1'b0;
    else         rts_q <= rts_d;
  end

  assign rts_n_o = rts_q;

  AST_RTS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !rts_n_o);  // R7
  AST_RTS_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && at_trig) |=> rts_n_o);  // R8
  AST_RTS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rts_n_o && !may_release) |=> rts_n_o);  // R9

endmodule

// File: rtl/rxq_trig_rts.sv
module rxq_trig_rts #(
  parameter int unsigned DEPTH = rxq_pkg::RXQ_DEPTH,
  parameter int unsigned DW    = rxq_pkg::RXQ_DW,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          flush_i,
  input  logic [CW-1:0] trig_i,
  input  logic          rts_en_i,
  input  logic [1:0]    hyst_i,
  input  logic          ovr_ack_i,
  output logic [CW-1:0] count_o,
  output logic          rx_rdy_o,
  output logic          rts_n_o,
  output logic          ovr_o
);

  import rxq_pkg::*;

  logic [CW-1:0] level;
  logic          wr_drop;

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .wr_req_i  (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_req_i  (rd_en_i),
    .rd_data_o (rd_data_o),
    .count_o   (level),
    .wr_drop_o (wr_drop)
  );

  rxq_ovr i_ovr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .drop_i (wr_drop),
    .ack_i  (ovr_ack_i),
    .ovr_o  (ovr_o)
  );

  rxq_rts #(.DEPTH(DEPTH)) i_rts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (rts_en_i),
    .trig_i  (trig_i),
    .hyst_i  (hyst_i),
    .count_i (level),
    .rts_n_o (rts_n_o)
  );

  assign count_o  = level;
  assign rx_rdy_o = int'(level) >= eff_trig(int'(trig_i), int'(DEPTH));

  AST_RDY_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_rdy_o) |-> (level != '0));  // R6

endmodule

// File: tb/test_rxq_trig_rts.sv
module test_rxq_trig_rts;

  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, flush = 1'b0, ack = 1'b0;
  logic [7:0] wd = '0;
  logic [6:0] trig = 7'd8;
  logic       rts_en = 1'b1;
  logic [1:0] hyst = 2'd1;
  logic [7:0] rd_data;
  logic [6:0] count;
  logic       rx_rdy, rts_n, ovr;

  always #5 clk = ~clk;

  rxq_trig_rts i_rxq_trig_rts (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wd),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .flush_i(flush), .trig_i(trig),
    .rts_en_i(rts_en), .hyst_i(hyst), .ovr_ack_i(ack), .count_o(count),
    .rx_rdy_o(rx_rdy), .rts_n_o(rts_n), .ovr_o(ovr)
  );

  int tests = 0, fails = 0, cycles = 0;

  // behavioural reference
  byte unsigned q[$];
  logic [7:0] m_rd = '0;
  logic m_ovr = 1'b0, m_rts = 1'b0;
  int m_et, m_h, m_n;
  bit m_drop;

  function automatic int m_trig(input int t);
    return t == 0 ? 1 : (t > DEPTH ? DEPTH : t);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_rd = '0; m_ovr = 1'b0; m_rts = 1'b0;
    end else begin
      m_et = m_trig(int'(trig));
      m_h  = (hyst == 0) ? 0 : (hyst == 1) ? 4 : (hyst == 2) ? 6 : 8;
      m_n  = q.size();
      if (!rts_en) m_rts = 1'b0;
      else if (m_n >= m_et) m_rts = 1'b1;
      else if (m_n == 0 || m_n + m_h < m_et) m_rts = 1'b0;
      m_drop = 0;
      if (flush) q.delete();
      else begin
        if (rd_en && m_n > 0) m_rd = q.pop_front();
        if (wr_en) begin
          if (m_n == DEPTH) m_drop = 1;
          else q.push_back(wd);
        end
      end
      if (m_drop) m_ovr = 1'b1;
      else if (ack) m_ovr = 1'b0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 count", int'(count), q.size());
      chk("R2/R5 rd_data", int'(rd_data), int'(m_rd));
      chk("R6 rx_rdy", int'(rx_rdy), int'(q.size() >= m_trig(int'(trig))));
      chk("R8/R9 rts_n", int'(rts_n), int'(m_rts));
      chk("R4 ovr", int'(ovr), int'(m_ovr));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(input bit w, input byte unsigned d, input bit r,
                      input bit f = 0, input bit a = 0);
    wr_en = w; wd = d; rd_en = r; flush = f; ack = a;
    @(negedge clk);
    wr_en = 0; rd_en = 0; flush = 0; ack = 0;
  endtask

  task automatic fill(input int n, input int base);
    for (int i = 0; i < n; i++) step(1, 8'(base + i), 0);
  endtask

  logic [7:0] saved;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count", int'(count), 0);
    chk("R1 rx_rdy", int'(rx_rdy), 0);
    chk("R1 rts_n", int'(rts_n), 0);
    chk("R1 ovr", int'(ovr), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // trigger 8, H=4: stop at 8, release below 4
    fill(10, 8'h11);
    step(0, 0, 0);
    chk("R8 rts stopped", int'(rts_n), 1);
    for (int i = 0; i < 7; i++) step(0, 0, 1);
    chk("R9 rts still held at count 3", int'(rts_n), 1);
    step(0, 0, 0);
    chk("R9 rts released", int'(rts_n), 0);
    chk("R2 order", int'(rd_data), 8'h11 + 6);

    // drain and read empty
    for (int i = 0; i < 3; i++) step(0, 0, 1);
    saved = rd_data;
    step(0, 0, 1); step(0, 0, 1);
    chk("R5 empty read hold", int'(rd_data), int'(saved));
    chk("R5 empty count", int'(count), 0);

    // overfill
    fill(70, 8'h40);
    chk("R3 count at full", int'(count), 64);
    chk("R3 ovr set", int'(ovr), 1);
    step(1, 8'hEE, 1);
    chk("R3 drop with read", int'(count), 63);
    step(1, 8'hEF, 0);
    step(1, 8'hF0, 0, 0, 1);
    chk("R4 set wins over ack", int'(ovr), 1);
    step(0, 0, 0, 0, 1);
    chk("R4 ack clears", int'(ovr), 0);

    // flush with write and read
    saved = rd_data;
    step(1, 8'h55, 1, 1);
    chk("R10 flushed", int'(count), 0);
    chk("R10 rd_data kept", int'(rd_data), int'(saved));
    step(0, 0, 0);

    // hysteresis codes with trigger 20
    trig = 7'd20;
    for (int c = 0; c < 4; c++) begin
      hyst = 2'(c);
      fill(22, 8'h80);
      for (int i = 0; i < 22; i++) step(0, 0, 1);
      step(0, 0, 0);
    end

    // trigger below H: release only at empty; trigger 0 and above depth
    trig = 7'd3; hyst = 2'd3;
    fill(5, 1); for (int i = 0; i < 5; i++) step(0, 0, 1); step(0, 0, 0);
    trig = 7'd0;
    step(1, 8'h9, 0); step(0, 0, 0);
    chk("R6 trigger 0 acts as 1", int'(rx_rdy), 1);
    step(0, 0, 1);
    trig = 7'd100;
    fill(64, 8'hA0); step(0, 0, 0);
    chk("R6 trigger clamp", int'(rx_rdy), 1);
    step(0, 0, 0, 1);

    // flow control off
    rts_en = 1'b0; trig = 7'd4;
    fill(30, 8'h20); step(0, 0, 0);
    chk("R7 rts low when disabled", int'(rts_n), 0);
    rts_en = 1'b1;

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0) begin
        trig = 7'($urandom_range(0, 70));
        hyst = 2'($urandom_range(0, 3));
        rts_en = ($urandom_range(0, 7) != 0);
      end
      step($urandom_range(0, 99) < 55, 8'($urandom), $urandom_range(0, 99) < 45,
           $urandom_range(0, 299) == 0, $urandom_range(0, 19) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule